// File: doc/BRIEF.md
# Multi-Source Prescaled IRQ Counter

A cartridge-side interrupt timer for an 8-bit console bus. Software programs it through eight byte-wide registers picked by a 3-bit offset. One of four bus events drives it: a CPU cycle, a rising edge of the PPU address line A12, a PPU read, or a CPU write. These events step a prescaler. Each time the prescaler wraps within its selected width, an 8-bit main counter moves one step in the same direction. When the main counter wraps, an active-high interrupt is latched, provided interrupts are enabled.

Loads of the prescaler and of the main counter are scrambled. The written byte is XORed with a key held in its own register before it is stored. A mode byte selects the event source, the count direction and the prescaler width. An optional adjust mask can replace the fixed width. The interrupt stays latched until software clears it through one of the disable writes.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset irq_o is low, interrupts are disabled, the mode byte is 0x00 (counter stopped) and the key, prescaler, counter and adjust byte are 0x00. Enabling alone then leaves irq_o low under any number of events.
- R2: A write at offset 0 sets the enable from data bit 0. When data bit 0 is 0, the write also clears a latched interrupt.
- R3: A write at offset 2 disables interrupts and clears a latched interrupt. A write at offset 3 enables interrupts and leaves a latched interrupt as it is.
- R4: Offset 1 holds the mode byte. Bits 1:0 pick the event source: 0 = cpu_cycle_i, 1 = rising edge of a12_i, 2 = ppu_rd_i, 3 = cpu_wr_i. Activity on sources that are not selected has no effect.
- R5: a12_i is asynchronous and passes through a two-stage synchroniser. Only its rising edges count. A rise presented before clock edge k is counted at edge k+2.
- R6: Mode bit 2 picks the prescaler width when mode bit 3 is clear: 3 bits when set (the main counter steps every 8 events), 8 bits when clear (every 256 events).
- R7: Mode bits 7:6 set the direction: 01 = up, 10 = down, 00 or 11 = stopped. When stopped, both the prescaler and the main counter hold their values.
- R8: Offset 6 stores an XOR key. Offset 4 loads the prescaler with data XOR key. Offset 5 loads the main counter with data XOR key.
- R9: Offset 7 stores an adjust mask, used only when mode bit 3 is set. The main counter then steps on an event whose pre-event prescaler bits under the mask are all ones (counting up) or all zeros (counting down). A mask of 0x00 steps on every event.
- R10: While enabled, the interrupt latches when the main counter steps from 0xFF to 0x00 (up) or from 0x00 to 0xFF (down). A wrap while disabled latches nothing.
- R11: A load of the main counter in the same cycle as an event wins over the step of that counter. The prescaler still takes the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register offset |
| wr_data_i | input | 8 | Write data |
| cpu_cycle_i | input | 1 | One-cycle pulse per CPU cycle |
| a12_i | input | 1 | Raw PPU address line A12 level |
| ppu_rd_i | input | 1 | One-cycle pulse per PPU read |
| cpu_wr_i | input | 1 | One-cycle pulse per CPU write |
| irq_o | output | 1 | Latched interrupt request, active high |

## Verification
The checker watches several properties on every cycle. The clearing writes at offsets 0 and 2 must drop irq_o one cycle later, and a write at offset 3 must keep a latched interrupt. A counter load must store data XOR key. In a stopped direction, nothing may move. Every rise of irq_o must match a real wrap of the main counter with the enable set. Other behaviours need the bench's scenarios, because they only show as the number of events before the interrupt: the prescaler widths and the adjust mask, the source selection, the A12 synchroniser delay and falling-edge rejection, and the load-versus-step race.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    SRC_CPU_CYC = 2'd0,
    SRC_A12     = 2'd1,
    SRC_PPU_RD  = 2'd2,
    SRC_CPU_WR  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    DIR_HOLD_A = 2'd0,
    DIR_UP     = 2'd1,
    DIR_DOWN   = 2'd2,
    DIR_HOLD_B = 2'd3
  } dir_e;

  typedef struct packed {
    dir_e       dir;
    logic [1:0] rsv;
    logic       use_adj;
    logic       narrow;
    src_e       src;
  } mode_t;

  localparam logic [2:0] OFS_EN   = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd1;
  localparam logic [2:0] OFS_OFF  = 3'd2;
  localparam logic [2:0] OFS_ON   = 3'd3;
  localparam logic [2:0] OFS_PRE  = 3'd4;
  localparam logic [2:0] OFS_CNT  = 3'd5;
  localparam logic [2:0] OFS_KEY  = 3'd6;
  localparam logic [2:0] OFS_ADJ  = 3'd7;

endpackage

// File: rtl/evt_select.sv
module evt_select
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic cpu_cycle_i,
  input  logic a12_i,
  input  logic ppu_rd_i,
  input  logic cpu_wr_i,
  output logic evt_o
);

  // sync stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] a12_sync_q;
  logic                 a12_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) a12_sync_q <= '0;
    else         a12_sync_q <= {a12_sync_q[SYNC_STAGES-1:0], a12_i};
  end

  assign a12_rise = a12_sync_q[SYNC_STAGES-1] & ~a12_sync_q[SYNC_STAGES];

  always_comb begin
    unique case (src_i)
      SRC_CPU_CYC: evt_o = cpu_cycle_i;
      SRC_A12:     evt_o = a12_rise;
      SRC_PPU_RD:  evt_o = ppu_rd_i;
      default:     evt_o = cpu_wr_i;
    endcase
  end

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int W        = 8,
  parameter int NARROW_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         up_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         narrow_i,
  input  logic         use_adj_i,
  input  logic [W-1:0] adj_i,
  output logic         carry_o,
  output logic [W-1:0] pre_o
);

  localparam logic [W-1:0] NarrowMask = W'((1 << NARROW_W) - 1);

  logic [W-1:0] pre_q;
  logic [W-1:0] mask;

  always_comb begin
    if (use_adj_i)     mask = adj_i;
    else if (narrow_i) mask = NarrowMask;
    else               mask = '1;
  end

  // carry when the masked field is at its terminal value before the step
  assign carry_o = evt_i && !load_i &&
                   (up_i ? (&(pre_q | ~mask)) : ~(|(pre_q & mask)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (load_i) pre_q <= load_val_i;
    else if (evt_i)  pre_q <= up_i ? pre_q + 1'b1 : pre_q - 1'b1;
  end

  assign pre_o = pre_q;

endmodule

// File: rtl/evt_main_ctr.sv
module evt_main_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && !load_i && (up_i ? (&cnt_q) : ~(|cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_irq_timer.sv
module evt_irq_timer
  import evt_timer_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NARROW_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cpu_cycle_i,
  input  logic          a12_i,
  input  logic          ppu_rd_i,
  input  logic          cpu_wr_i,
  output logic          irq_o
);

  localparam int ModeW = $bits(mode_t);

  mode_t         mode_q;
  logic          en_q;
  logic          pend_q;
  logic [DW-1:0] key_q;
  logic [DW-1:0] adj_q;
  logic [DW-1:0] load_val;
  logic [DW-1:0] pre_q;
  logic [DW-1:0] cnt_q;
  logic [1:0]    dir_w;
  logic          wr_en, wr_mode, wr_off, wr_on, wr_pre, wr_cnt, wr_key, wr_adj;
  logic          evt_raw, evt, run, up, step, wrap, clr;

  assign wr_en   = wr_en_i && wr_addr_i == OFS_EN;
  assign wr_mode = wr_en_i && wr_addr_i == OFS_MODE;
  assign wr_off  = wr_en_i && wr_addr_i == OFS_OFF;
  assign wr_on   = wr_en_i && wr_addr_i == OFS_ON;
  assign wr_pre  = wr_en_i && wr_addr_i == OFS_PRE;
  assign wr_cnt  = wr_en_i && wr_addr_i == OFS_CNT;
  assign wr_key  = wr_en_i && wr_addr_i == OFS_KEY;
  assign wr_adj  = wr_en_i && wr_addr_i == OFS_ADJ;

  assign load_val = wr_data_i ^ key_q;
  assign dir_w    = mode_q.dir;
  assign run      = (mode_q.dir == DIR_UP) || (mode_q.dir == DIR_DOWN);
  assign up       = mode_q.dir == DIR_UP;
  assign evt      = evt_raw && run;
  assign clr      = wr_off || (wr_en && !wr_data_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      key_q  <= '0;
      adj_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wr_data_i[ModeW-1:0]);
      if (wr_en)   en_q   <= wr_data_i[0];
      else if (wr_off) en_q <= 1'b0;
      else if (wr_on)  en_q <= 1'b1;
      if (wr_key)  key_q  <= wr_data_i;
      if (wr_adj)  adj_q  <= wr_data_i;
    end
  end

  // clearing writes win over a wrap in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (clr)          pend_q <= 1'b0;
    else if (wrap && en_q) pend_q <= 1'b1;
  end

  assign irq_o = pend_q;

  evt_select #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (mode_q.src),
    .cpu_cycle_i(cpu_cycle_i),
    .a12_i      (a12_i),
    .ppu_rd_i   (ppu_rd_i),
    .cpu_wr_i   (cpu_wr_i),
    .evt_o      (evt_raw)
  );

  evt_prescaler #(
    .W       (DW),
    .NARROW_W(NARROW_W)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .up_i      (up),
    .load_i    (wr_pre),
    .load_val_i(load_val),
    .narrow_i  (mode_q.narrow),
    .use_adj_i (mode_q.use_adj),
    .adj_i     (adj_q),
    .carry_o   (step),
    .pre_o     (pre_q)
  );

  evt_main_ctr #(
    .W(DW)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .up_i      (up),
    .load_i    (wr_cnt),
    .load_val_i(load_val),
    .wrap_o    (wrap),
    .cnt_o     (cnt_q)
  );

endmodule

// File: rtl/evt_irq_timer_chk.sv
module evt_irq_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          irq_o,
  input logic          en_q,
  input logic [1:0]    dir_w,
  input logic [DW-1:0] key_q,
  input logic [DW-1:0] pre_q,
  input logic [DW-1:0] cnt_q
);

  logic stopped, ld_any;
  assign stopped = (dir_w == 2'b00) || (dir_w == 2'b11);
  assign ld_any  = wr_en_i && (wr_addr_i == 3'd4 || wr_addr_i == 3'd5);

  AST_CLR_BY_EN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0 && !wr_data_i[0]) |=> !irq_o); // R2

  AST_CLR_BY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd2) |=> !irq_o); // R3

  AST_ON_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd3 && irq_o) |=> irq_o); // R3

  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped && !ld_any) |=> ($stable(cnt_q) && $stable(pre_q))); // R7

  AST_CNT_LOAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd5) |=> cnt_q == $past(wr_data_i ^ key_q)); // R8

  AST_IRQ_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(en_q) &&
      (($past(cnt_q) == '1 && cnt_q == '0) || ($past(cnt_q) == '0 && cnt_q == '1)))); // R10

endmodule

bind evt_irq_timer evt_irq_timer_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .irq_o    (irq_o),
  .en_q     (en_q),
  .dir_w    (dir_w),
  .key_q    (key_q),
  .pre_q    (pre_q),
  .cnt_q    (cnt_q)
);

// File: tb/evt_irq_timer_test.sv
`timescale 1ns/1ps
module evt_irq_timer_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       cpu_cycle_i = 1'b0;
  logic       a12_i = 1'b0;
  logic       ppu_rd_i = 1'b0;
  logic       cpu_wr_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_irq_timer uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cpu_cycle_i(cpu_cycle_i),
    .a12_i      (a12_i),
    .ppu_rd_i   (ppu_rd_i),
    .cpu_wr_i   (cpu_wr_i),
    .irq_o      (irq_o)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o actual=%b expected=%b", req, irq_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // src: 0 cpu_cycle, 1 ppu_rd, 2 cpu_wr; held for n cycles
  task automatic pulse(input int src, input int n);
    if (n > 0) begin
      @(negedge clk_i);
      case (src)
        0: cpu_cycle_i = 1'b1;
        1: ppu_rd_i = 1'b1;
        default: cpu_wr_i = 1'b1;
      endcase
      repeat (n) @(negedge clk_i);
      cpu_cycle_i = 1'b0; ppu_rd_i = 1'b0; cpu_wr_i = 1'b0;
    end
  endtask

  task automatic setup(input logic [7:0] mode, input logic [7:0] pre, input logic [7:0] cnt);
    wr(3'd2, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd1, mode);
    wr(3'd4, pre);
    wr(3'd5, cnt);
  endtask

  task automatic t_reset();
    chk(1'b0, "R1 reset");
    wr(3'd3, 8'h00);
    pulse(0, 300);
    chk(1'b0, "R1 stopped after reset");
  endtask

  task automatic t_up_narrow();
    setup(8'h44, 8'h00, 8'hFE);
    wr(3'd3, 8'h00);
    pulse(0, 15);
    chk(1'b0, "R6 narrow before wrap");
    pulse(0, 1);
    chk(1'b1, "R10 up wrap");
    wr(3'd2, 8'h00);
    chk(1'b0, "R3 off clears");
  endtask

  task automatic t_key();
    setup(8'h44, 8'h00, 8'h00);
    wr(3'd6, 8'h5A);
    wr(3'd4, 8'h5D);
    wr(3'd5, 8'hA5);
    wr(3'd0, 8'h01);
    chk(1'b0, "R8 no irq before event");
    pulse(0, 1);
    chk(1'b1, "R8 key loads");
    wr(3'd3, 8'h00);
    chk(1'b1, "R3 on keeps pending");
    wr(3'd0, 8'h00);
    chk(1'b0, "R2 en0 clears");
  endtask

  task automatic t_wide();
    setup(8'h40, 8'h00, 8'hFF);
    wr(3'd3, 8'h00);
    pulse(0, 255);
    chk(1'b0, "R6 wide before wrap");
    pulse(0, 1);
    chk(1'b1, "R6 wide wrap");
  endtask

  task automatic t_down();
    setup(8'h82, 8'h01, 8'h00);
    wr(3'd3, 8'h00);
    pulse(1, 1);
    chk(1'b0, "R7 down first");
    pulse(1, 1);
    chk(1'b1, "R7 down wrap");
  endtask

  task automatic t_stopped();
    setup(8'hC4, 8'h07, 8'hFF);
    wr(3'd3, 8'h00);
    pulse(0, 20);
    chk(1'b0, "R7 stopped");
    wr(3'd1, 8'h44);
    pulse(0, 1);
    chk(1'b1, "R7 state held while stopped");
  endtask

  task automatic t_src();
    setup(8'h47, 8'h07, 8'hFF);
    wr(3'd3, 8'h00);
    pulse(0, 3);
    pulse(1, 3);
    @(negedge clk_i); a12_i = 1'b1;
    repeat (4) @(negedge clk_i);
    a12_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(1'b0, "R4 unselected ignored");
    pulse(2, 1);
    chk(1'b1, "R4 cpu write source");
  endtask

  task automatic t_a12();
    setup(8'h45, 8'h06, 8'hFF);
    wr(3'd3, 8'h00);
    @(negedge clk_i); a12_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(1'b0, "R5 one rise only");
    a12_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(1'b0, "R5 fall ignored");
    a12_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(1'b0, "R5 sync latency");
    @(negedge clk_i);
    chk(1'b1, "R5 rise counted");
    a12_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_adj();
    wr(3'd7, 8'h00);
    setup(8'h48, 8'h00, 8'hFE);
    wr(3'd3, 8'h00);
    pulse(0, 1);
    chk(1'b0, "R9 mask0 first");
    pulse(0, 1);
    chk(1'b1, "R9 mask0 every event");
    wr(3'd7, 8'h03);
    setup(8'h48, 8'h00, 8'hFF);
    wr(3'd3, 8'h00);
    pulse(0, 3);
    chk(1'b0, "R9 mask3 early");
    pulse(0, 1);
    chk(1'b1, "R9 mask3 wrap");
    wr(3'd7, 8'h00);
    setup(8'h44, 8'h00, 8'hFF);
    wr(3'd3, 8'h00);
    pulse(0, 7);
    chk(1'b0, "R9 adjust ignored without bit3");
    pulse(0, 1);
    chk(1'b1, "R9 narrow wrap");
  endtask

  task automatic t_disabled();
    setup(8'h44, 8'h07, 8'hFF);
    pulse(0, 1);
    chk(1'b0, "R10 no latch when disabled");
    wr(3'd3, 8'h00);
    chk(1'b0, "R10 no deferred latch");
  endtask

  task automatic t_race();
    setup(8'h44, 8'h07, 8'h10);
    wr(3'd3, 8'h00);
    @(negedge clk_i);
    cpu_cycle_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 8'hFF;
    @(negedge clk_i);
    cpu_cycle_i = 1'b0; wr_en_i = 1'b0;
    chk(1'b0, "R11 load wins");
    pulse(0, 7);
    chk(1'b0, "R11 prescaler took event");
    pulse(0, 1);
    chk(1'b1, "R11 wrap after load");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_up_narrow();
    t_key();
    t_wide();
    t_down();
    t_stopped();
    t_src();
    t_a12();
    t_adj();
    t_disabled();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule